// File: doc/BRIEF.md
# Word-strided byte register bridge

The block is a slave on a 32-bit bus with the classic cycle/strobe/acknowledge handshake. Behind that bus it holds a bank of eight 8-bit control registers of the kind a serial port controller uses. Each register takes a full 32-bit word, so software reaches register n at byte address 4·n. The register byte always travels in the least significant lane. Writes are gated by the byte-select line of that lane. Read data is driven from the current address on every cycle, with no read enable, and the upper 24 bits are zero.

Some offsets mean one thing on a read and another on a write. Offset 0 reads the receive byte and writes the transmit holding byte. Offset 2 reads the interrupt identification and writes the FIFO control. Bit 7 of the line control register switches offsets 0 and 1 over to the low and high bytes of the baud divisor.

The serial engine itself is not part of the block. The receive byte, the interrupt identification, the line status and the modem status arrive on input ports. The written control bytes leave on output ports. Loading the transmit byte and reading the receive byte each produce a one-cycle pulse for that engine.

Top module: `wbreg_bridge`

## Requirements
- R1: After a clock edge at which cyc_i and stb_i are both high and ack_o is low, ack_o is high for exactly one cycle. ack_o then goes low even if stb_i stays high. No request means no acknowledge.
- R2: The register offset is byte address bits 4:2, so register n sits at byte address 4·n. Address bits 1:0 have no effect on which register is read or written.
- R3: A write changes state only when sel_i[0] is 1, and only dat_i[7:0] is stored. sel_i[3:1] and dat_i[31:8] are ignored.
- R4: dat_o shows the register chosen by adr_i on every cycle, whatever the values of cyc_i, stb_i, we_i and sel_i, and dat_o[31:8] is always 0.
- R5: With line control bit 7 clear, a write to offset 0 with sel_i[0]=1 stores the byte on tx_data_o and raises tx_load_o for one cycle, in the same cycle as ack_o. A read at offset 0 returns rx_data_i.
- R6: With line control bit 7 clear, a read at offset 0 raises rx_read_o for one cycle, in the same cycle as ack_o, whatever sel_i holds. No other access raises rx_read_o.
- R7: Offset 1 is read/write interrupt enable (ier_o). Offset 2 reads iid_i and a write to it stores fcr_o. Offset 3 is read/write line control (lcr_o).
- R8: Offset 4 is read/write modem control (mcr_o). Offsets 5 and 6 read lsr_i and msr_i, and writes to them change nothing. Offset 7 is a scratch byte that reads back the last value written.
- R9: With lcr_o[7]=1, offsets 0 and 1 read and write the divisor low byte (div_lo_o) and high byte (div_hi_o). No tx_load_o or rx_read_o pulse occurs, and the transmit and interrupt-enable bytes are left unchanged.
- R10: While rst_n is low, and for the two cycles after it is released, every writable register, ack_o, tx_load_o and rx_read_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Transfer strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | 5 | Byte address; bits 4:2 select the register |
| sel_i | input | 4 | Byte lane selects; only bit 0 gates writes |
| dat_i | input | 32 | Write data; bits 7:0 used |
| dat_o | output | 32 | Read data, always driven, upper 24 bits zero |
| ack_o | output | 1 | One-cycle transfer acknowledge |
| rx_data_i | input | 8 | Received byte from the serial engine |
| iid_i | input | 8 | Interrupt identification byte |
| lsr_i | input | 8 | Line status byte |
| msr_i | input | 8 | Modem status byte |
| tx_load_o | output | 1 | One-cycle pulse: transmit byte loaded |
| tx_data_o | output | 8 | Transmit holding byte |
| rx_read_o | output | 1 | One-cycle pulse: receive byte read |
| ier_o | output | 8 | Interrupt enable byte |
| fcr_o | output | 8 | FIFO control byte |
| lcr_o | output | 8 | Line control byte; bit 7 selects divisor access |
| mcr_o | output | 8 | Modem control byte |
| div_lo_o | output | 8 | Divisor low byte |
| div_hi_o | output | 8 | Divisor high byte |

## Verification
Assertions check on every cycle that:
- the acknowledge follows a request and never lasts two cycles;
- both side-effect pulses coincide with the acknowledge and each lasts one cycle;
- no register moves without a lane-0 write strobe;
- writes to the status offsets leave the bank alone;
- divisor mode suppresses the transmit pulse.

Only the bench's scenarios can show the following:
- the word-stride decode, including ignored address bits 1:0;
- the exact byte each offset returns for each state of line control bit 7;
- that masked and upper lanes leave stored values intact;
- that the read path follows the address outside any bus cycle.

// File: rtl/wbreg_pkg.sv
package wbreg_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned OFS_W    = $clog2(NUM_REGS);
  localparam int unsigned DIV_BIT  = 7;

  typedef enum logic [OFS_W-1:0] {
    OFS_DATA = 3'd0,
    OFS_IER  = 3'd1,
    OFS_IDFC = 3'd2,
    OFS_LCR  = 3'd3,
    OFS_MCR  = 3'd4,
    OFS_LSR  = 3'd5,
    OFS_MSR  = 3'd6,
    OFS_SCR  = 3'd7
  } ofs_e;

  typedef struct packed {
    logic [REG_W-1:0] thr;
    logic [REG_W-1:0] ier;
    logic [REG_W-1:0] fcr;
    logic [REG_W-1:0] lcr;
    logic [REG_W-1:0] mcr;
    logic [REG_W-1:0] scr;
    logic [REG_W-1:0] dll;
    logic [REG_W-1:0] dlm;
  } bank_t;
endpackage

// File: rtl/wbreg_rst_sync.sv
module wbreg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/wbreg_wb_if.sv
module wbreg_wb_if
  import wbreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES  = DATA_W / 8,
  localparam int unsigned LANE_SH = $clog2(LANES),
  localparam int unsigned ADDR_W = LANE_SH + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [LANES-1:0]  sel_i,
  output logic              ack_o,
  output ofs_e              ofs_o,
  output logic              wr_en_o,
  output logic              rd_en_o
);
  logic             ack_q;
  logic             ack_d;
  logic             req;
  logic [LANES-1:0] lane_we;

  assign req = cyc_i & stb_i & ~ack_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l] = req & we_i & sel_i[l];
  end

  assign wr_en_o = lane_we[0];
  assign rd_en_o = req & ~we_i;
  assign ofs_o   = ofs_e'(adr_i[LANE_SH +: OFS_W]);

  wire unused_wbif = ^{lane_we, adr_i[LANE_SH-1:0]};

  always_comb ack_d = req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign ack_o = ack_q;

  assert_ack_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_i && stb_i && !ack_o) |=> ack_o);
  assert_ack_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
  assert_ack_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_i && stb_i) |=> !ack_o);
endmodule

// File: rtl/wbreg_bank.sv
module wbreg_bank
  import wbreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  ofs_e             ofs_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] rx_data_i,
  input  logic [REG_W-1:0] iid_i,
  input  logic [REG_W-1:0] lsr_i,
  input  logic [REG_W-1:0] msr_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             tx_load_o,
  output logic [REG_W-1:0] tx_data_o,
  output logic             rx_read_o,
  output logic [REG_W-1:0] ier_o,
  output logic [REG_W-1:0] fcr_o,
  output logic [REG_W-1:0] lcr_o,
  output logic [REG_W-1:0] mcr_o,
  output logic [REG_W-1:0] div_lo_o,
  output logic [REG_W-1:0] div_hi_o
);
  bank_t bank_q;
  bank_t bank_d;
  logic  div_mode;
  logic  en_thr, en_ier, en_fcr, en_lcr, en_mcr, en_scr, en_dll, en_dlm;
  logic  tx_load_q, tx_load_d;
  logic  rx_read_q, rx_read_d;

  assign div_mode = bank_q.lcr[DIV_BIT];

  always_comb begin
    en_thr = wr_en_i && (ofs_i == OFS_DATA) && !div_mode;
    en_dll = wr_en_i && (ofs_i == OFS_DATA) &&  div_mode;
    en_ier = wr_en_i && (ofs_i == OFS_IER)  && !div_mode;
    en_dlm = wr_en_i && (ofs_i == OFS_IER)  &&  div_mode;
    en_fcr = wr_en_i && (ofs_i == OFS_IDFC);
    en_lcr = wr_en_i && (ofs_i == OFS_LCR);
    en_mcr = wr_en_i && (ofs_i == OFS_MCR);
    en_scr = wr_en_i && (ofs_i == OFS_SCR);
  end

  always_comb begin
    bank_d = bank_q;
    if (en_thr) bank_d.thr = wdata_i;
    if (en_ier) bank_d.ier = wdata_i;
    if (en_fcr) bank_d.fcr = wdata_i;
    if (en_lcr) bank_d.lcr = wdata_i;
    if (en_mcr) bank_d.mcr = wdata_i;
    if (en_scr) bank_d.scr = wdata_i;
    if (en_dll) bank_d.dll = wdata_i;
    if (en_dlm) bank_d.dlm = wdata_i;
    tx_load_d = en_thr;
    rx_read_d = rd_en_i && (ofs_i == OFS_DATA) && !div_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q    <= '0;
      tx_load_q <= 1'b0;
      rx_read_q <= 1'b0;
    end else begin
      bank_q    <= bank_d;
      tx_load_q <= tx_load_d;
      rx_read_q <= rx_read_d;
    end
  end

  always_comb begin
    unique case (ofs_i)
      OFS_DATA: rdata_o = div_mode ? bank_q.dll : rx_data_i;
      OFS_IER:  rdata_o = div_mode ? bank_q.dlm : bank_q.ier;
      OFS_IDFC: rdata_o = iid_i;
      OFS_LCR:  rdata_o = bank_q.lcr;
      OFS_MCR:  rdata_o = bank_q.mcr;
      OFS_LSR:  rdata_o = lsr_i;
      OFS_MSR:  rdata_o = msr_i;
      OFS_SCR:  rdata_o = bank_q.scr;
      default:  rdata_o = '0;
    endcase
  end

  assign tx_load_o = tx_load_q;
  assign rx_read_o = rx_read_q;
  assign tx_data_o = bank_q.thr;
  assign ier_o     = bank_q.ier;
  assign fcr_o     = bank_q.fcr;
  assign lcr_o     = bank_q.lcr;
  assign mcr_o     = bank_q.mcr;
  assign div_lo_o  = bank_q.dll;
  assign div_hi_o  = bank_q.dlm;

  assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(bank_q));
  assert_status_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (ofs_i == OFS_LSR || ofs_i == OFS_MSR)) |=> $stable(bank_q));
  assert_tx_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_o |=> !tx_load_o);
  assert_rx_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_read_o |=> !rx_read_o);
  assert_div_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div_mode |=> !(tx_load_o || rx_read_o));
endmodule

// File: rtl/wbreg_bridge.sv
module wbreg_bridge
  import wbreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES  = DATA_W / 8,
  localparam int unsigned ADDR_W = $clog2(LANES) + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [LANES-1:0]  sel_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic [DATA_W-1:0] dat_o,
  output logic              ack_o,
  input  logic [REG_W-1:0]  rx_data_i,
  input  logic [REG_W-1:0]  iid_i,
  input  logic [REG_W-1:0]  lsr_i,
  input  logic [REG_W-1:0]  msr_i,
  output logic              tx_load_o,
  output logic [REG_W-1:0]  tx_data_o,
  output logic              rx_read_o,
  output logic [REG_W-1:0]  ier_o,
  output logic [REG_W-1:0]  fcr_o,
  output logic [REG_W-1:0]  lcr_o,
  output logic [REG_W-1:0]  mcr_o,
  output logic [REG_W-1:0]  div_lo_o,
  output logic [REG_W-1:0]  div_hi_o
);
  logic             rst_n_sync;
  ofs_e             ofs;
  logic             wr_en;
  logic             rd_en;
  logic [REG_W-1:0] rdata;

  wbreg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_sync)
  );

  wbreg_wb_if #(.DATA_W(DATA_W)) u_wb_if (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .cyc_i   (cyc_i),
    .stb_i   (stb_i),
    .we_i    (we_i),
    .adr_i   (adr_i),
    .sel_i   (sel_i),
    .ack_o   (ack_o),
    .ofs_o   (ofs),
    .wr_en_o (wr_en),
    .rd_en_o (rd_en)
  );

  wbreg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wr_en_i   (wr_en),
    .rd_en_i   (rd_en),
    .ofs_i     (ofs),
    .wdata_i   (dat_i[REG_W-1:0]),
    .rx_data_i (rx_data_i),
    .iid_i     (iid_i),
    .lsr_i     (lsr_i),
    .msr_i     (msr_i),
    .rdata_o   (rdata),
    .tx_load_o (tx_load_o),
    .tx_data_o (tx_data_o),
    .rx_read_o (rx_read_o),
    .ier_o     (ier_o),
    .fcr_o     (fcr_o),
    .lcr_o     (lcr_o),
    .mcr_o     (mcr_o),
    .div_lo_o  (div_lo_o),
    .div_hi_o  (div_hi_o)
  );

  assign dat_o = {{(DATA_W-REG_W){1'b0}}, rdata};

  wire unused_top = ^dat_i[DATA_W-1:REG_W];

  assert_pulse_with_ack_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (tx_load_o || rx_read_o) |-> ack_o);
  assert_pulses_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(tx_load_o && rx_read_o));
  assert_ack_quiet_in_reset_R10: assert property (@(posedge clk)
    !rst_n_sync |-> !ack_o);
endmodule

// File: tb/wbreg_bridge_bench.sv
module wbreg_bridge_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_i, stb_i, we_i;
  logic [4:0]  adr_i;
  logic [3:0]  sel_i;
  logic [31:0] dat_i;
  logic [31:0] dat_o;
  logic        ack_o;
  logic [7:0]  rx_data_i, iid_i, lsr_i, msr_i;
  logic        tx_load_o, rx_read_o;
  logic [7:0]  tx_data_o, ier_o, fcr_o, lcr_o, mcr_o, div_lo_o, div_hi_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] m_thr, m_ier, m_fcr, m_lcr, m_mcr, m_scr, m_dll, m_dlm;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbreg_bridge u_wbreg_bridge (
    .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .adr_i(adr_i), .sel_i(sel_i), .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o),
    .rx_data_i(rx_data_i), .iid_i(iid_i), .lsr_i(lsr_i), .msr_i(msr_i),
    .tx_load_o(tx_load_o), .tx_data_o(tx_data_o), .rx_read_o(rx_read_o),
    .ier_o(ier_o), .fcr_o(fcr_o), .lcr_o(lcr_o), .mcr_o(mcr_o),
    .div_lo_o(div_lo_o), .div_hi_o(div_hi_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [2:0] o);
    logic dm;
    logic [7:0] v;
    dm = m_lcr[7];
    case (o)
      3'd0: v = dm ? m_dll : rx_data_i;
      3'd1: v = dm ? m_dlm : m_ier;
      3'd2: v = iid_i;
      3'd3: v = m_lcr;
      3'd4: v = m_mcr;
      3'd5: v = lsr_i;
      3'd6: v = msr_i;
      default: v = m_scr;
    endcase
    return {24'h0, v};
  endfunction

  task automatic model_write(input logic [2:0] o, input logic [7:0] d);
    logic dm;
    dm = m_lcr[7];
    case (o)
      3'd0: if (dm) m_dll = d; else m_thr = d;
      3'd1: if (dm) m_dlm = d; else m_ier = d;
      3'd2: m_fcr = d;
      3'd3: m_lcr = d;
      3'd4: m_mcr = d;
      3'd7: m_scr = d;
      default: ;
    endcase
  endtask

  task automatic check_outputs();
    chk("R5 tx_data_o", {24'h0, tx_data_o}, {24'h0, m_thr});
    chk("R7 ier_o",     {24'h0, ier_o},     {24'h0, m_ier});
    chk("R7 fcr_o",     {24'h0, fcr_o},     {24'h0, m_fcr});
    chk("R7 lcr_o",     {24'h0, lcr_o},     {24'h0, m_lcr});
    chk("R8 mcr_o",     {24'h0, mcr_o},     {24'h0, m_mcr});
    chk("R9 div_lo_o",  {24'h0, div_lo_o},  {24'h0, m_dll});
    chk("R9 div_hi_o",  {24'h0, div_hi_o},  {24'h0, m_dlm});
  endtask

  task automatic xfer(input logic w, input logic [2:0] o, input logic [1:0] lo,
                      input logic [3:0] s, input logic [31:0] d);
    logic exp_tx, exp_rx;
    logic [31:0] exp_rd;
    exp_tx = w && (o == 3'd0) && !m_lcr[7] && s[0];
    exp_rx = !w && (o == 3'd0) && !m_lcr[7];
    exp_rd = model_read(o);
    @(negedge clk);
    cyc_i = 1'b1; stb_i = 1'b1; we_i = w; adr_i = {o, lo}; sel_i = s; dat_i = d;
    @(negedge clk);
    chk("R1 ack high", {31'h0, ack_o}, 32'h1);
    chk("R5 tx_load_o", {31'h0, tx_load_o}, {31'h0, exp_tx});
    if (exp_tx) chk("R5 tx byte", {24'h0, tx_data_o}, {24'h0, d[7:0]});
    chk("R6 rx_read_o", {31'h0, rx_read_o}, {31'h0, exp_rx});
    if (!w) chk("R2 read data", dat_o, exp_rd);
    if (w && s[0]) model_write(o, d[7:0]);
    cyc_i = 1'b0; stb_i = 1'b0; we_i = 1'b0;
    @(negedge clk);
    chk("R1 ack single", {31'h0, ack_o}, 32'h0);
    chk("R5 tx pulse single", {31'h0, tx_load_o}, 32'h0);
    chk("R6 rx pulse single", {31'h0, rx_read_o}, 32'h0);
    check_outputs();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; cyc_i = 0; stb_i = 0; we_i = 0; adr_i = '0; sel_i = '0; dat_i = '0;
    rx_data_i = 8'h3C; iid_i = 8'hC1; lsr_i = 8'h60; msr_i = 8'hB0;
    {m_thr, m_ier, m_fcr, m_lcr, m_mcr, m_scr, m_dll, m_dlm} = '0;
    repeat (5) @(negedge clk);
    chk("R10 ack in reset", {31'h0, ack_o}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10 ack", {31'h0, ack_o}, 32'h0);
    chk("R10 pulses", {30'h0, tx_load_o, rx_read_o}, 32'h0);
    check_outputs();

    // R4: read path live outside a bus cycle, ignoring we/sel
    adr_i = {3'd5, 2'b00}; we_i = 1'b1; sel_i = 4'b0000; #1;
    chk("R4 idle read lsr", dat_o, 32'h60);
    adr_i = {3'd6, 2'b10}; #1;
    chk("R4 idle read msr", dat_o, 32'hB0);
    we_i = 1'b0;

    // R2: low address bits ignored
    xfer(1'b1, 3'd7, 2'b11, 4'b0001, 32'h0000_005A);
    xfer(1'b0, 3'd7, 2'b00, 4'b0000, 32'h0);
    // R3: masked lane 0 leaves scratch; upper lanes dropped
    xfer(1'b1, 3'd7, 2'b00, 4'b1110, 32'hFFFF_FFFF);
    xfer(1'b0, 3'd7, 2'b01, 4'b1111, 32'h0);
    xfer(1'b1, 3'd7, 2'b00, 4'b0001, 32'hAABB_CC11);
    adr_i = {3'd7, 2'b00}; #1;
    chk("R3 upper lanes dropped", dat_o, 32'h11);

    // R5: transmit load, R6: receive read
    xfer(1'b1, 3'd0, 2'b00, 4'b0001, 32'h0000_00E7);
    xfer(1'b1, 3'd0, 2'b00, 4'b0010, 32'h0000_0099);
    xfer(1'b0, 3'd0, 2'b00, 4'b1000, 32'h0);

    // R7: ier, fcr vs iid, lcr
    xfer(1'b1, 3'd1, 2'b00, 4'b0001, 32'h0F);
    xfer(1'b1, 3'd2, 2'b00, 4'b0001, 32'hC7);
    xfer(1'b0, 3'd2, 2'b00, 4'b0001, 32'h0);
    chk("R7 iid read not fcr", dat_o, 32'hC1);

    // R8: status offsets read-only
    xfer(1'b1, 3'd5, 2'b00, 4'b1111, 32'h12);
    xfer(1'b1, 3'd6, 2'b00, 4'b1111, 32'h34);
    xfer(1'b0, 3'd5, 2'b00, 4'b0001, 32'h0);
    xfer(1'b1, 3'd4, 2'b00, 4'b0001, 32'h1F);

    // R9: divisor access
    xfer(1'b1, 3'd3, 2'b00, 4'b0001, 32'h83);
    xfer(1'b1, 3'd0, 2'b00, 4'b0001, 32'h1B);
    xfer(1'b1, 3'd1, 2'b00, 4'b0001, 32'h02);
    xfer(1'b0, 3'd0, 2'b00, 4'b0001, 32'h0);
    xfer(1'b0, 3'd1, 2'b00, 4'b0001, 32'h0);
    xfer(1'b1, 3'd3, 2'b00, 4'b0001, 32'h03);
    xfer(1'b0, 3'd1, 2'b00, 4'b0001, 32'h0);

    // R1: strobe held through the acknowledge
    @(negedge clk);
    cyc_i = 1; stb_i = 1; we_i = 0; adr_i = {3'd7, 2'b00};
    @(negedge clk);
    chk("R1 ack on hold", {31'h0, ack_o}, 32'h1);
    @(negedge clk);
    chk("R1 ack drops while stb held", {31'h0, ack_o}, 32'h0);
    cyc_i = 0; stb_i = 0;
    @(negedge clk);
    chk("R1 no ack without req", {31'h0, ack_o}, 32'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      rx_data_i = 8'($urandom); iid_i = 8'($urandom);
      lsr_i = 8'($urandom); msr_i = 8'($urandom);
      xfer(1'($urandom), o, 2'($urandom), 4'($urandom), $urandom);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule